// File: doc/BRIEF.md
# SDRAM Command Front End with Bank and Power Tracking

This block sits on the device side of a single-data-rate mobile SDRAM interface. On every rising clock edge it samples the command pins (chip select, row strobe, column strobe, write enable), the two bank-select bits, the thirteen address lines and the clock enable. It turns them into one-cycle command strobes and keeps a per-bank record of whether a row is open and which row it is.

Address bit 10 has two roles. On a precharge it widens the target from one bank to all four. On a read or write it asks for the bank to be closed once the burst completes. The burst length comes from the low bits of the standard mode register. Mode-register loads go to the standard or the extended register, chosen by the bank bits. Illegal accesses raise an error pulse and are dropped.

Dropping the clock enable moves the block into one of four low-power states, chosen from what is in progress. While it is in any of them, no command has any effect. Self-refresh is left as soon as the clock enable rises, without waiting for a clock edge.

Top module: `sdr_cmd_front`

## Requirements
- R1: After a synchronous reset all banks read idle, every strobe, the error flag and the precharge mask are 0, the power mode is RUN (0), the standard mode register holds 13'h0002 and the extended register holds 0.
- R2: On an active edge (power mode RUN, CKE high), the pin code {cs_n,ras_n,cas_n,we_n} selects the command: 0011 ACTIVATE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 REFRESH, 0000 MODE LOAD. The matching strobe is high for the one cycle after that edge. cs_n high, 0111 and 0110 produce no strobe.
- R3: An accepted ACTIVATE opens bank ba and stores addr as that bank's row. row_o and sel_bank_o show the row and the bank.
- R4: An accepted READ or WRITE puts addr[8:0] on col_o and addr[10] on auto_pre_o. With addr[10] high, the bank closes on the active edge BL edges after the command. BL is 1, 2, 4 or 8 for standard-mode bits [2:0] equal to 0, 1, 2 or any other value. A newer READ or WRITE replaces the pending burst.
- R5: PRECHARGE with addr[10] high closes all banks whatever ba holds. With addr[10] low it closes bank ba only. pre_mask_o shows the closed set (bit n for bank n).
- R6: MODE LOAD with ba=00 writes addr to the standard register. With ba=10 it writes addr to the extended register. With ba=01 or 11 it changes neither.
- R7: READ or WRITE to an idle bank, or ACTIVATE to an open bank, pulses cmd_err_o for one cycle. The command gives no strobe and changes no state.
- R8: On an edge in RUN with CKE low, the new power mode is chosen in this order: burst in progress gives SUSPEND (3); otherwise any open bank gives ACTIVE POWER-DOWN (2); otherwise a REFRESH code gives SELF REFRESH (4); otherwise PRECHARGE POWER-DOWN (1). The command on that edge is not executed.
- R9: While in any mode other than RUN, all command pins are ignored. The burst count does not advance, and banks, rows and mode registers hold.
- R10: From modes 1, 2 or 3, the first edge with CKE high returns the mode to RUN. The command on that edge is ignored.
- R11: In SELF REFRESH, pwr_mode_o reads RUN as soon as CKE goes high, before any clock edge. The following edge leaves the mode and ignores its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select / mode register select |
| addr | input | 13 | Row, column, bit-10 flag or mode value |
| cmd_act_o | output | 1 | ACTIVATE accepted |
| cmd_rd_o | output | 1 | READ accepted |
| cmd_wr_o | output | 1 | WRITE accepted |
| cmd_pre_o | output | 1 | PRECHARGE accepted |
| cmd_ref_o | output | 1 | REFRESH accepted |
| cmd_mrs_o | output | 1 | MODE LOAD accepted |
| cmd_err_o | output | 1 | Illegal access rejected |
| sel_bank_o | output | 2 | Bank of last bank command |
| row_o | output | 13 | Row of last ACTIVATE |
| col_o | output | 9 | Column of last READ/WRITE |
| auto_pre_o | output | 1 | Close-after-burst flag of last READ/WRITE |
| pre_mask_o | output | 4 | Banks closed by last PRECHARGE |
| bank_open_o | output | 4 | Per-bank open flag |
| open_rows_o | output | 52 | Per-bank row, bank n at [13n+12:13n] |
| std_mode_o | output | 13 | Standard mode register |
| ext_mode_o | output | 13 | Extended mode register |
| pwr_mode_o | output | 3 | Power mode 0..4 |

## Verification
The hardest state to reach is clock suspend. It needs a READ or WRITE accepted with a long burst length, then CKE dropped within that burst, then a command issued while suspended. The bench reaches it by first loading a burst length of eight through a mode load, then lowering CKE on the edge right after the read. It checks that the remaining burst resumes where it stopped once CKE is back.

Self-refresh exit also takes deliberate stimulus. CKE is raised in mid-cycle, the mode output is sampled before the next edge, and an ACTIVATE placed on the exit edge must leave every bank idle.

// File: rtl/sdr_fe_pkg.sv
package sdr_fe_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    PWR_RUN      = 3'd0,
    PWR_PRE_PD   = 3'd1,
    PWR_ACT_PD   = 3'd2,
    PWR_SUSPEND  = 3'd3,
    PWR_SELF_REF = 3'd4
  } sdr_pwr_e;

  localparam logic [1:0] SEL_STD_MODE = 2'b00;
  localparam logic [1:0] SEL_EXT_MODE = 2'b10;
  localparam int         BURST_MAX    = 8;

endpackage

// File: rtl/sdr_cmd_dec.sv
module sdr_cmd_dec
  import sdr_fe_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdr_cmd_e cmd
);

  always_comb begin
    case ({cs_n, ras_n, cas_n, we_n})
      4'b0011: cmd = CMD_ACT;
      4'b0101: cmd = CMD_RD;
      4'b0100: cmd = CMD_WR;
      4'b0010: cmd = CMD_PRE;
      4'b0001: cmd = CMD_REF;
      4'b0000: cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdr_mode_regs.sv
module sdr_mode_regs
  import sdr_fe_pkg::*;
#(
  parameter int             AW      = 13,
  parameter int             CNT_W   = 4,
  parameter logic [AW-1:0]  STD_RST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [1:0]       sel,
  input  logic [AW-1:0]    data,
  output logic [AW-1:0]    std_q,
  output logic [AW-1:0]    ext_q,
  output logic [CNT_W-1:0] burst_len
);

  always_ff @(posedge clk) begin
    if (rst) begin
      std_q <= STD_RST;
      ext_q <= '0;
    end else if (load) begin
      if (sel == SEL_STD_MODE) begin
        std_q <= data;
      end else if (sel == SEL_EXT_MODE) begin
        ext_q <= data;
      end
    end
  end

  always_comb begin
    case (std_q[2:0])
      3'd0:    burst_len = CNT_W'(1);
      3'd1:    burst_len = CNT_W'(2);
      3'd2:    burst_len = CNT_W'(4);
      default: burst_len = CNT_W'(BURST_MAX);
    endcase
  end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_fe_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int AW     = 13,
  parameter int CNT_W  = 4,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  sdr_cmd_e          cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [AW-1:0]     addr,
  input  logic [CNT_W-1:0]  burst_len,
  output logic [BANKS-1:0]  bank_open,
  output logic [BANKS*AW-1:0] rows,
  output logic              busy,
  output logic              cmd_ok,
  output logic              cmd_bad
);

  logic [CNT_W-1:0] cnt_q;
  logic             ap_pend_q;
  logic [BA_W-1:0]  ap_bank_q;
  logic             sel_open;
  logic             is_rdwr;
  logic             burst_end;

  assign sel_open  = bank_open[ba];
  assign is_rdwr   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign cmd_bad   = active && ((is_rdwr && !sel_open) || ((cmd == CMD_ACT) && sel_open));
  assign cmd_ok    = active && (cmd != CMD_NOP) && !cmd_bad;
  assign busy      = (cnt_q != '0);
  assign burst_end = active && (cnt_q == CNT_W'(1)) && ap_pend_q;

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic          open_r;
    logic [AW-1:0] row_r;
    logic          hit;

    assign hit = (ba == BA_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (active) begin
        if (burst_end && (ap_bank_q == BA_W'(i))) begin
          open_r <= 1'b0;
        end
        if (cmd_ok && (cmd == CMD_ACT) && hit) begin
          open_r <= 1'b1;
          row_r  <= addr;
        end
        if (cmd_ok && (cmd == CMD_PRE) && (addr[AP_BIT] || hit)) begin
          open_r <= 1'b0;
        end
      end
    end

    assign bank_open[i]         = open_r;
    assign rows[i*AW +: AW]     = row_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_bank_q <= '0;
    end else if (active) begin
      if (cmd_ok && is_rdwr) begin
        cnt_q     <= burst_len;
        ap_pend_q <= addr[AP_BIT];
        ap_bank_q <= ba;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          ap_pend_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sdr_pwr_ctrl.sv
module sdr_pwr_ctrl
  import sdr_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cke,
  input  sdr_cmd_e cmd,
  input  logic     busy,
  input  logic     any_open,
  output logic     active,
  output logic [2:0] mode
);

  sdr_pwr_e state_q;
  sdr_pwr_e state_d;

  assign active = (state_q == PWR_RUN) && cke;

  always_comb begin
    state_d = state_q;
    if (state_q == PWR_RUN) begin
      if (!cke) begin
        if (busy) begin
          state_d = PWR_SUSPEND;
        end else if (any_open) begin
          state_d = PWR_ACT_PD;
        end else if (cmd == CMD_REF) begin
          state_d = PWR_SELF_REF;
        end else begin
          state_d = PWR_PRE_PD;
        end
      end
    end else if (cke) begin
      state_d = PWR_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PWR_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  // Self-refresh exit shows up without waiting for a clock edge
  always_comb begin
    if ((state_q == PWR_SELF_REF) && cke) begin
      mode = PWR_RUN;
    end else begin
      mode = state_q;
    end
  end

endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
  import sdr_fe_pkg::*;
#(
  parameter int            BANKS    = 4,
  parameter int            AW       = 13,
  parameter int            COL_W    = 9,
  parameter int            AP_BIT   = 10,
  parameter logic [AW-1:0] STD_RST  = 2,
  localparam int           BA_W     = $clog2(BANKS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     ba,
  input  logic [AW-1:0]       addr,
  output logic                cmd_act_o,
  output logic                cmd_rd_o,
  output logic                cmd_wr_o,
  output logic                cmd_pre_o,
  output logic                cmd_ref_o,
  output logic                cmd_mrs_o,
  output logic                cmd_err_o,
  output logic [BA_W-1:0]     sel_bank_o,
  output logic [AW-1:0]       row_o,
  output logic [COL_W-1:0]    col_o,
  output logic                auto_pre_o,
  output logic [BANKS-1:0]    pre_mask_o,
  output logic [BANKS-1:0]    bank_open_o,
  output logic [BANKS*AW-1:0] open_rows_o,
  output logic [AW-1:0]       std_mode_o,
  output logic [AW-1:0]       ext_mode_o,
  output logic [2:0]          pwr_mode_o
);

  localparam int CNT_W = $clog2(BURST_MAX + 1);

  sdr_cmd_e         cmd;
  logic             active;
  logic             busy;
  logic             cmd_ok;
  logic             cmd_bad;
  logic [CNT_W-1:0] burst_len;
  logic             bank_cmd;
  logic             rdwr_cmd;

  sdr_cmd_dec u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdr_pwr_ctrl u_pwr (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .cmd      (cmd),
    .busy     (busy),
    .any_open (|bank_open_o),
    .active   (active),
    .mode     (pwr_mode_o)
  );

  sdr_bank_track #(
    .BANKS  (BANKS),
    .AW     (AW),
    .CNT_W  (CNT_W),
    .AP_BIT (AP_BIT)
  ) u_banks (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .burst_len (burst_len),
    .bank_open (bank_open_o),
    .rows      (open_rows_o),
    .busy      (busy),
    .cmd_ok    (cmd_ok),
    .cmd_bad   (cmd_bad)
  );

  sdr_mode_regs #(
    .AW      (AW),
    .CNT_W   (CNT_W),
    .STD_RST (STD_RST)
  ) u_mode (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd_ok && (cmd == CMD_MRS)),
    .sel       (ba),
    .data      (addr),
    .std_q     (std_mode_o),
    .ext_q     (ext_mode_o),
    .burst_len (burst_len)
  );

  assign rdwr_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign bank_cmd = rdwr_cmd || (cmd == CMD_ACT) || (cmd == CMD_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_act_o  <= 1'b0;
      cmd_rd_o   <= 1'b0;
      cmd_wr_o   <= 1'b0;
      cmd_pre_o  <= 1'b0;
      cmd_ref_o  <= 1'b0;
      cmd_mrs_o  <= 1'b0;
      cmd_err_o  <= 1'b0;
      sel_bank_o <= '0;
      row_o      <= '0;
      col_o      <= '0;
      auto_pre_o <= 1'b0;
      pre_mask_o <= '0;
    end else begin
      cmd_act_o <= cmd_ok && (cmd == CMD_ACT);
      cmd_rd_o  <= cmd_ok && (cmd == CMD_RD);
      cmd_wr_o  <= cmd_ok && (cmd == CMD_WR);
      cmd_pre_o <= cmd_ok && (cmd == CMD_PRE);
      cmd_ref_o <= cmd_ok && (cmd == CMD_REF);
      cmd_mrs_o <= cmd_ok && (cmd == CMD_MRS);
      cmd_err_o <= cmd_bad;
      if (cmd_ok && bank_cmd) begin
        sel_bank_o <= ba;
      end
      if (cmd_ok && (cmd == CMD_ACT)) begin
        row_o <= addr;
      end
      if (cmd_ok && rdwr_cmd) begin
        col_o      <= addr[COL_W-1:0];
        auto_pre_o <= addr[AP_BIT];
      end
      if (cmd_ok && (cmd == CMD_PRE)) begin
        pre_mask_o <= addr[AP_BIT] ? {BANKS{1'b1}} : (BANKS'(1) << ba);
      end
    end
  end

endmodule

// File: rtl/sdr_front_chk.sv
module sdr_front_chk #(
  parameter int BANKS = 4,
  parameter int AW    = 13,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_act_o,
  input logic                cmd_rd_o,
  input logic                cmd_wr_o,
  input logic                cmd_pre_o,
  input logic                cmd_ref_o,
  input logic                cmd_mrs_o,
  input logic                cmd_err_o,
  input logic [BA_W-1:0]     sel_bank_o,
  input logic [AW-1:0]       row_o,
  input logic [BANKS-1:0]    pre_mask_o,
  input logic [BANKS-1:0]    bank_open_o,
  input logic [BANKS*AW-1:0] open_rows_o,
  input logic [2:0]          pwr_mode_o
);

  logic any_pulse;
  assign any_pulse = cmd_act_o | cmd_rd_o | cmd_wr_o | cmd_pre_o |
                     cmd_ref_o | cmd_mrs_o | cmd_err_o;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o, cmd_ref_o, cmd_mrs_o, cmd_err_o})); // R2

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    cmd_act_o |-> (bank_open_o[sel_bank_o] &&
                   (open_rows_o[int'(sel_bank_o)*AW +: AW] == row_o))); // R3

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    cmd_pre_o |-> ((bank_open_o & pre_mask_o) == '0)); // R5

  AST_SREF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_o == 3'd4) |-> (bank_open_o == '0)); // R8

  AST_LP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_o != 3'd0) |-> !any_pulse); // R9

  AST_LP_BANKS_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((pwr_mode_o != 3'd0) && ($past(pwr_mode_o) != 3'd0)) |-> $stable(bank_open_o)); // R9

  AST_EXIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (($past(pwr_mode_o) == 3'd1) && (pwr_mode_o == 3'd0)) |-> !any_pulse); // R10

endmodule

bind sdr_cmd_front sdr_front_chk #(.BANKS(BANKS), .AW(AW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_act_o   (cmd_act_o),
  .cmd_rd_o    (cmd_rd_o),
  .cmd_wr_o    (cmd_wr_o),
  .cmd_pre_o   (cmd_pre_o),
  .cmd_ref_o   (cmd_ref_o),
  .cmd_mrs_o   (cmd_mrs_o),
  .cmd_err_o   (cmd_err_o),
  .sel_bank_o  (sel_bank_o),
  .row_o       (row_o),
  .pre_mask_o  (pre_mask_o),
  .bank_open_o (bank_open_o),
  .open_rows_o (open_rows_o),
  .pwr_mode_o  (pwr_mode_o)
);

// File: tb/test_sdr_cmd_front.sv
module test_sdr_cmd_front;

  localparam int CLK_PERIOD = 10;

  // bench command codes
  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                 K_REF = 5, K_MRS = 6, K_DESEL = 7, K_STOP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;

  logic        cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o, cmd_ref_o, cmd_mrs_o, cmd_err_o;
  logic [1:0]  sel_bank_o;
  logic [12:0] row_o;
  logic [8:0]  col_o;
  logic        auto_pre_o;
  logic [3:0]  pre_mask_o;
  logic [3:0]  bank_open_o;
  logic [51:0] open_rows_o;
  logic [12:0] std_mode_o, ext_mode_o;
  logic [2:0]  pwr_mode_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_front i_sdr_cmd_front (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_act_o(cmd_act_o), .cmd_rd_o(cmd_rd_o), .cmd_wr_o(cmd_wr_o),
    .cmd_pre_o(cmd_pre_o), .cmd_ref_o(cmd_ref_o), .cmd_mrs_o(cmd_mrs_o),
    .cmd_err_o(cmd_err_o), .sel_bank_o(sel_bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .pre_mask_o(pre_mask_o), .bank_open_o(bank_open_o),
    .open_rows_o(open_rows_o), .std_mode_o(std_mode_o), .ext_mode_o(ext_mode_o),
    .pwr_mode_o(pwr_mode_o)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string ctx = "R1";

  // reference model state
  int m_open[4];
  int m_row[4];
  int m_cnt, m_ap, m_apb, m_pw, m_std, m_ext;
  int m_strobe;   // bit5 act .. bit0 mrs
  int m_err, m_bank, m_rowo, m_col, m_apo, m_mask;

  function automatic int pin_code(logic c, logic r, logic a, logic w);
    if (c) return K_NOP;
    case ({r, a, w})
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return K_PRE;
      3'b001: return K_REF;
      3'b000: return K_MRS;
      default: return K_NOP;
    endcase
  endfunction

  function automatic int blen(int s);
    case (s & 7)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    m_cnt = 0; m_ap = 0; m_apb = 0; m_pw = 0; m_std = 2; m_ext = 0;
    m_strobe = 0; m_err = 0; m_bank = 0; m_rowo = 0; m_col = 0; m_apo = 0; m_mask = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      int c, b, a, run, bad, anyo;
      c = pin_code(cs_n, ras_n, cas_n, we_n);
      b = int'(ba);
      a = int'(addr);
      anyo = (m_open[0] | m_open[1] | m_open[2] | m_open[3]);
      run = (m_pw == 0) && cke;
      m_strobe = 0;
      m_err = 0;
      if (m_pw == 0) begin
        if (!cke) begin
          if (m_cnt > 0) m_pw = 3;
          else if (anyo != 0) m_pw = 2;
          else if (c == K_REF) m_pw = 4;
          else m_pw = 1;
        end
      end else if (cke) begin
        m_pw = 0;
      end
      if (run) begin
        bad = (((c == K_RD) || (c == K_WR)) && !m_open[b]) || ((c == K_ACT) && m_open[b]);
        if (bad) m_err = 1;
        if ((m_cnt == 1) && m_ap) m_open[m_apb] = 0;
        if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) m_ap = 0;
        end
        if (!bad) begin
          case (c)
            K_ACT: begin
              m_open[b] = 1; m_row[b] = a; m_strobe = 32; m_bank = b; m_rowo = a;
            end
            K_RD, K_WR: begin
              m_strobe = (c == K_RD) ? 16 : 8;
              m_bank = b; m_col = a % 512; m_apo = (a >> 10) & 1;
              m_cnt = blen(m_std); m_ap = (a >> 10) & 1; m_apb = b;
            end
            K_PRE: begin
              m_strobe = 4; m_bank = b;
              if ((a >> 10) & 1) begin
                for (int i = 0; i < 4; i++) m_open[i] = 0;
                m_mask = 15;
              end else begin
                m_open[b] = 0; m_mask = 1 << b;
              end
            end
            K_REF: m_strobe = 2;
            K_MRS: begin
              m_strobe = 1;
              if (b == 0) m_std = a;
              else if (b == 2) m_ext = a;
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [5:0]  es, as;
    logic [51:0] er;
    int          epw;
    es = 6'(m_strobe);
    as = {cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o, cmd_ref_o, cmd_mrs_o};
    for (int i = 0; i < 4; i++) er[i*13 +: 13] = 13'(m_row[i]);
    epw = ((m_pw == 4) && cke) ? 0 : m_pw;
    check(as == es, "R2 strobes", 64'(as), 64'(es));
    check(cmd_err_o == 1'(m_err), "R7 error", 64'(cmd_err_o), 64'(m_err));
    check(bank_open_o == 4'({m_open[3][0], m_open[2][0], m_open[1][0], m_open[0][0]}),
          "R3/R5 bank_open", 64'(bank_open_o),
          64'({m_open[3][0], m_open[2][0], m_open[1][0], m_open[0][0]}));
    check(open_rows_o == er, "R3 rows", 64'(open_rows_o), 64'(er));
    check(sel_bank_o == 2'(m_bank) && row_o == 13'(m_rowo), "R3 bank/row",
          64'({sel_bank_o, row_o}), 64'({2'(m_bank), 13'(m_rowo)}));
    check(col_o == 9'(m_col) && auto_pre_o == 1'(m_apo), "R4 col/ap",
          64'({auto_pre_o, col_o}), 64'({1'(m_apo), 9'(m_col)}));
    check(pre_mask_o == 4'(m_mask), "R5 mask", 64'(pre_mask_o), 64'(m_mask));
    check(std_mode_o == 13'(m_std) && ext_mode_o == 13'(m_ext), "R6 mode regs",
          64'({std_mode_o, ext_mode_o}), 64'({13'(m_std), 13'(m_ext)}));
    check(pwr_mode_o == 3'(epw), "R8 power mode", 64'(pwr_mode_o), 64'(epw));
  endtask

  task automatic drive(input int c, input int b, input int a, input bit k);
    cke = k;
    ba = 2'(b);
    addr = 13'(a);
    case (c)
      K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      K_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      K_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
      K_STOP:  {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
  endtask

  task automatic issue(input int c, input int b, input int a, input bit k);
    @(negedge clk);
    compare_all();
    drive(c, b, a, k);
  endtask

  task automatic idle(input int n, input bit k);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 0, k);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) #1;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    drive(K_NOP, 0, 0, 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ctx = "R1";
    idle(2, 1);
    check(bank_open_o == 4'h0 && pwr_mode_o == 3'd0, "R1 idle after reset",
          64'({bank_open_o, pwr_mode_o}), 64'h0);
    check(std_mode_o == 13'h0002 && ext_mode_o == 13'h0, "R1 mode reset",
          64'({std_mode_o, ext_mode_o}), 64'({13'h0002, 13'h0}));

    ctx = "R2 no-op codes";
    issue(K_DESEL, 1, 13'h0555, 1);
    issue(K_STOP, 0, 0, 1);
    issue(K_NOP, 0, 0, 1);
    idle(1, 1);

    ctx = "R3 activate";
    issue(K_ACT, 0, 13'h1ABC, 1);
    issue(K_ACT, 2, 13'h0123, 1);
    idle(1, 1);

    ctx = "R7 illegal";
    issue(K_ACT, 0, 13'h0777, 1);
    issue(K_RD, 1, 13'h0011, 1);
    issue(K_WR, 3, 13'h0022, 1);
    idle(1, 1);

    ctx = "R4 read/write";
    issue(K_RD, 0, 13'h01A5, 1);
    issue(K_WR, 2, 13'h0433, 1);
    idle(6, 1);

    ctx = "R6 mode load";
    issue(K_MRS, 0, 13'h0000, 1);
    issue(K_MRS, 2, 13'h1234, 1);
    issue(K_MRS, 1, 13'h1555, 1);
    issue(K_MRS, 3, 13'h0AAA, 1);
    ctx = "R4 burst one";
    issue(K_ACT, 1, 13'h0040, 1);
    issue(K_RD, 1, 13'h0401, 1);
    idle(2, 1);
    ctx = "R6 burst eight";
    issue(K_MRS, 0, 13'h0003, 1);
    issue(K_ACT, 3, 13'h0ABC, 1);
    issue(K_WR, 3, 13'h0407, 1);
    issue(K_RD, 0, 13'h0009, 1);
    idle(10, 1);

    ctx = "R5 precharge";
    issue(K_ACT, 1, 13'h0101, 1);
    issue(K_ACT, 2, 13'h0202, 1);
    issue(K_ACT, 3, 13'h0303, 1);
    issue(K_PRE, 1, 13'h0000, 1);
    issue(K_PRE, 3, 13'h0400, 1);
    idle(1, 1);

    ctx = "R8 active power-down";
    issue(K_ACT, 0, 13'h0042, 1);
    issue(K_NOP, 0, 0, 0);
    ctx = "R9 ignored in power-down";
    issue(K_PRE, 0, 13'h0400, 0);
    issue(K_ACT, 1, 13'h0011, 0);
    ctx = "R10 exit edge";
    issue(K_PRE, 0, 13'h0400, 1);
    idle(2, 1);

    ctx = "R8 suspend";
    issue(K_RD, 0, 13'h0005, 1);
    issue(K_NOP, 0, 0, 0);
    ctx = "R9 suspend frozen";
    issue(K_PRE, 0, 13'h0400, 0);
    issue(K_MRS, 0, 13'h0000, 0);
    idle(3, 0);
    ctx = "R10 suspend exit";
    idle(10, 1);
    issue(K_PRE, 0, 13'h0400, 1);
    idle(1, 1);

    ctx = "R8 precharge power-down";
    issue(K_NOP, 0, 0, 0);
    idle(2, 0);
    ctx = "R10 leave";
    issue(K_ACT, 2, 13'h0066, 1);
    idle(1, 1);
    issue(K_PRE, 0, 13'h0400, 1);

    ctx = "R8 self refresh";
    issue(K_REF, 0, 0, 0);
    idle(3, 0);
    ctx = "R11 async exit";
    @(negedge clk);
    compare_all();
    check(pwr_mode_o == 3'd4, "R11 before exit", 64'(pwr_mode_o), 64'd4);
    drive(K_ACT, 1, 13'h0077, 1);
    #1;
    check(pwr_mode_o == 3'd0, "R11 mode without clock", 64'(pwr_mode_o), 64'd0);
    idle(2, 1);

    ctx = "R8 refresh with open bank";
    issue(K_ACT, 1, 13'h0099, 1);
    issue(K_REF, 0, 0, 0);
    idle(1, 0);
    idle(2, 1);
    issue(K_REF, 0, 0, 1);
    issue(K_PRE, 0, 13'h0400, 1);
    issue(K_REF, 0, 0, 1);
    idle(1, 1);

    ctx = "R2/R7 mixed traffic";
    for (int n = 0; n < 600; n++) begin
      int c;
      c = $urandom_range(0, 8);
      issue(c, $urandom_range(0, 3), $urandom_range(0, 8191), ($urandom_range(0, 11) != 0));
    end
    idle(4, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule